// File: doc/BRIEF.md
# Immediate Decoder and Next-PC Selector

This combinational unit sits beside the decode stage of a 32-bit RISC-V core. From the instruction word it rebuilds the sign-extended immediate for the current encoding format. From the two source register values and the function field it decides whether a conditional branch is taken. It also produces the address of the next instruction. The link value that jump instructions write to their destination register is always available, whether or not that register is x0.

The control decoder drives a two-bit program-counter source select. The unit builds the branch target, the register-indirect target and the jump target in parallel, and the select picks one of them or the sequential address. When the branch source is selected but the condition does not hold, the sequential address is used.

Top module: `rv_npc_unit`

## Requirements
- R1: For opcodes 0000011 (load), 0010011 (immediate ALU) and 1100111 (indirect jump), `imm_o` is instr[31:20] sign-extended to 32 bits.
- R2: For opcode 0100011 (store), `imm_o` is {instr[31:25], instr[11:7]} sign-extended.
- R3: For opcode 1100011 (branch), `imm_o` is {instr[31], instr[7], instr[30:25], instr[11:8], 1'b0} sign-extended.
- R4: For opcodes 0110111 and 0010111 (upper immediate), `imm_o` is {instr[31:12], 12'b0}.
- R5: For opcode 1101111 (direct jump), `imm_o` is {instr[31], instr[19:12], instr[20], instr[30:21], 1'b0} sign-extended. This gives a reach of about ±1 MiB.
- R6: For any other opcode, `imm_o` is zero.
- R7: `br_taken_o` is 1 only when the opcode is 1100011 and the condition selected by instr[14:12] holds on rs1 and rs2: 000 equal, 001 not equal, 100 signed less, 101 signed greater-or-equal, 110 unsigned less, 111 unsigned greater-or-equal. Codes 010 and 011 are never taken.
- R8: With `pc_src_i` = 00, `next_pc_o` is pc+4.
- R9: With `pc_src_i` = 01, `next_pc_o` is pc plus the R3 offset when `br_taken_o` is 1, and pc+4 otherwise.
- R10: With `pc_src_i` = 10, `next_pc_o` is rs1 plus the sign-extended instr[31:20], without scaling, and with bit 0 forced to 0.
- R11: With `pc_src_i` = 11, `next_pc_o` is pc plus the R5 offset.
- R12: `link_o` is pc+4 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of the instruction |
| rs1_i | input | 32 | First source register value |
| rs2_i | input | 32 | Second source register value |
| pc_src_i | input | 2 | Next-PC source: 00 sequential, 01 branch, 10 register-indirect, 11 jump |
| imm_o | output | 32 | Format-dependent sign-extended immediate |
| br_taken_o | output | 1 | Conditional branch decision |
| next_pc_o | output | 32 | Selected next instruction address |
| link_o | output | 32 | Return address pc+4 |

## Verification
Two functions meet in the same evaluation: the branch decision and the next-PC select. With the branch source selected, a false condition has to give the sequential address, not the branch target. The bench pairs branch words with each select value and with register pairs that are equal, differ only in sign, or differ only in magnitude. Its reference model gives the taken flag, the immediate and the next address from a separate arithmetic formulation, and all three are compared on the same clock.

// File: rtl/rvnpc_pkg.sv
package rvnpc_pkg;
  typedef enum logic [1:0] {
    PCS_SEQ = 2'd0,
    PCS_BR  = 2'd1,
    PCS_IND = 2'd2,
    PCS_JMP = 2'd3
  } pc_src_e;

  typedef enum logic [2:0] {
    FMT_NONE = 3'd0,
    FMT_I    = 3'd1,
    FMT_S    = 3'd2,
    FMT_B    = 3'd3,
    FMT_U    = 3'd4,
    FMT_J    = 3'd5
  } imm_fmt_e;

  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;

  localparam logic [2:0] CMP_EQ  = 3'b000;
  localparam logic [2:0] CMP_NE  = 3'b001;
  localparam logic [2:0] CMP_LT  = 3'b100;
  localparam logic [2:0] CMP_GE  = 3'b101;
  localparam logic [2:0] CMP_LTU = 3'b110;
  localparam logic [2:0] CMP_GEU = 3'b111;

  function automatic imm_fmt_e fmt_of(input logic [6:0] opc);
    case (opc)
      OPC_LOAD, OPC_OPIMM, OPC_JALR: fmt_of = FMT_I;
      OPC_STORE:                     fmt_of = FMT_S;
      OPC_BRANCH:                    fmt_of = FMT_B;
      OPC_LUI, OPC_AUIPC:            fmt_of = FMT_U;
      OPC_JAL:                       fmt_of = FMT_J;
      default:                       fmt_of = FMT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/rvnpc_imm_gen.sv
module rvnpc_imm_gen
  import rvnpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr,
  output imm_fmt_e        fmt,
  output logic [XLEN-1:0] imm,
  output logic [XLEN-1:0] off_i,
  output logic [XLEN-1:0] off_b,
  output logic [XLEN-1:0] off_j
);
  localparam int IW = 12;
  localparam int JW = 21;
  localparam int UW = 32;

  function automatic logic [XLEN-1:0] sx12(input logic [IW-1:0] v);
    sx12 = {{(XLEN-IW){v[IW-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] sx13(input logic [IW:0] v);
    sx13 = {{(XLEN-IW-1){v[IW]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] sx21(input logic [JW-1:0] v);
    sx21 = {{(XLEN-JW){v[JW-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] sx32(input logic [UW-1:0] v);
    sx32 = {{(XLEN-UW){v[UW-1]}}, v};
  endfunction

  logic [XLEN-1:0] off_s;
  logic [XLEN-1:0] off_u;

  assign fmt   = fmt_of(instr[6:0]);
  assign off_i = sx12(instr[31:20]);
  assign off_s = sx12({instr[31:25], instr[11:7]});
  assign off_b = sx13({instr[31], instr[7], instr[30:25], instr[11:8], 1'b0});
  assign off_j = sx21({instr[31], instr[19:12], instr[20], instr[30:21], 1'b0});
  assign off_u = sx32({instr[31:12], 12'b0});

  always_comb begin
    case (fmt)
      FMT_I:   imm = off_i;
      FMT_S:   imm = off_s;
      FMT_B:   imm = off_b;
      FMT_U:   imm = off_u;
      FMT_J:   imm = off_j;
      default: imm = '0;
    endcase
  end

  always_comb begin
    if (fmt == FMT_NONE)
      a_r6_unknown_zero: assert (imm == '0) else $error("imm not zero for unknown opcode");
    if (fmt == FMT_U)
      a_r4_upper_low_clear: assert (imm[11:0] == 12'd0) else $error("upper imm low bits set");
    if (fmt == FMT_B || fmt == FMT_J)
      a_r3_half_aligned: assert (imm[0] == 1'b0) else $error("scaled offset odd");
    if (fmt != FMT_NONE && fmt != FMT_U)
      a_r1_sign_follows_msb: assert (imm[XLEN-1] == instr[31]) else $error("sign bit mismatch");
  end
endmodule

// File: rtl/rvnpc_br_cond.sv
module rvnpc_br_cond
  import rvnpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            is_branch,
  input  logic [2:0]      cmp_op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            taken
);
  logic eq_w;
  logic lt_s_w;
  logic lt_u_w;
  logic cond_w;

  assign eq_w   = (a == b);
  assign lt_s_w = ($signed(a) < $signed(b));
  assign lt_u_w = (a < b);

  always_comb begin
    case (cmp_op)
      CMP_EQ:  cond_w = eq_w;
      CMP_NE:  cond_w = !eq_w;
      CMP_LT:  cond_w = lt_s_w;
      CMP_GE:  cond_w = !lt_s_w;
      CMP_LTU: cond_w = lt_u_w;
      CMP_GEU: cond_w = !lt_u_w;
      default: cond_w = 1'b0;
    endcase
  end

  assign taken = is_branch & cond_w;

  always_comb begin
    if (cmp_op == 3'b010 || cmp_op == 3'b011)
      a_r7_reserved_not_taken: assert (!taken) else $error("reserved compare taken");
    if (eq_w)
      a_r7_equal_not_less: assert (!lt_s_w && !lt_u_w) else $error("equal yet less");
  end
endmodule

// File: rtl/rvnpc_pc_mux.sv
module rvnpc_pc_mux
  import rvnpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] rs1,
  input  logic [XLEN-1:0] off_i,
  input  logic [XLEN-1:0] off_b,
  input  logic [XLEN-1:0] off_j,
  input  logic            taken,
  input  pc_src_e         sel,
  output logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] link
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  function automatic logic [XLEN-1:0] rel_target(input logic [XLEN-1:0] base,
                                                 input logic [XLEN-1:0] off);
    rel_target = base + off;
  endfunction

  function automatic logic [XLEN-1:0] ind_target(input logic [XLEN-1:0] base,
                                                 input logic [XLEN-1:0] off);
    logic [XLEN-1:0] sum;
    sum = base + off;
    ind_target = {sum[XLEN-1:1], 1'b0};
  endfunction

  logic [XLEN-1:0] seq_tgt;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] ind_tgt;
  logic [XLEN-1:0] jmp_tgt;

  assign seq_tgt = rel_target(pc, STEP);
  assign br_tgt  = rel_target(pc, off_b);
  assign ind_tgt = ind_target(rs1, off_i);
  assign jmp_tgt = rel_target(pc, off_j);
  assign link    = seq_tgt;

  always_comb begin
    case (sel)
      PCS_BR:  next_pc = taken ? br_tgt : seq_tgt;
      PCS_IND: next_pc = ind_tgt;
      PCS_JMP: next_pc = jmp_tgt;
      default: next_pc = seq_tgt;
    endcase
  end

  always_comb begin
    a_r10_ind_even: assert (ind_tgt[0] == 1'b0) else $error("indirect target odd");
    if (sel == PCS_SEQ)
      a_r8_seq_is_link: assert (next_pc == link) else $error("sequential path not link");
    if (sel == PCS_BR && !taken)
      a_r9_fallthrough: assert (next_pc == link) else $error("untaken branch redirected");
    if (pc[0] == 1'b0)
      a_r11_jump_aligned: assert (jmp_tgt[0] == 1'b0 && br_tgt[0] == 1'b0) else $error("relative target odd");
  end
endmodule

// File: rtl/rv_npc_unit.sv
module rv_npc_unit
  import rvnpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  input  logic [1:0]      pc_src_i,
  output logic [XLEN-1:0] imm_o,
  output logic            br_taken_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic [XLEN-1:0] link_o
);
  imm_fmt_e        fmt_w;
  logic [XLEN-1:0] off_i_w;
  logic [XLEN-1:0] off_b_w;
  logic [XLEN-1:0] off_j_w;
  logic            is_branch_w;
  pc_src_e         sel_w;

  assign is_branch_w = (instr_i[6:0] == OPC_BRANCH);
  assign sel_w       = pc_src_e'(pc_src_i);

  rvnpc_imm_gen #(.XLEN(XLEN)) u_imm (
    .instr (instr_i),
    .fmt   (fmt_w),
    .imm   (imm_o),
    .off_i (off_i_w),
    .off_b (off_b_w),
    .off_j (off_j_w)
  );

  rvnpc_br_cond #(.XLEN(XLEN)) u_cmp (
    .is_branch (is_branch_w),
    .cmp_op    (instr_i[14:12]),
    .a         (rs1_i),
    .b         (rs2_i),
    .taken     (br_taken_o)
  );

  rvnpc_pc_mux #(.XLEN(XLEN)) u_mux (
    .pc      (pc_i),
    .rs1     (rs1_i),
    .off_i   (off_i_w),
    .off_b   (off_b_w),
    .off_j   (off_j_w),
    .taken   (br_taken_o),
    .sel     (sel_w),
    .next_pc (next_pc_o),
    .link    (link_o)
  );

  always_comb begin
    if (br_taken_o)
      a_r7_taken_needs_branch: assert (fmt_w == FMT_B) else $error("taken without branch opcode");
    if (fmt_w == FMT_B)
      a_r3_imm_matches_offset: assert (imm_o == off_b_w) else $error("branch imm differs from target offset");
  end
endmodule

// File: tb/rv_npc_unit_tb.sv
module rv_npc_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int N_RANDOM   = 4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] pc = '0;
  logic [31:0] rs1 = '0;
  logic [31:0] rs2 = '0;
  logic [1:0]  pc_src = '0;
  logic [31:0] imm;
  logic        br_taken;
  logic [31:0] next_pc;
  logic [31:0] link;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rv_npc_unit dut_i (
    .instr_i    (instr),
    .pc_i       (pc),
    .rs1_i      (rs1),
    .rs2_i      (rs2),
    .pc_src_i   (pc_src),
    .imm_o      (imm),
    .br_taken_o (br_taken),
    .next_pc_o  (next_pc),
    .link_o     (link)
  );

  // Reference model: shift-and-mask formulation of the immediates.
  function automatic logic [31:0] sgn(input logic [31:0] w);
    sgn = 32'($signed(w) >>> 31);
  endfunction
  function automatic logic [31:0] m_i(input logic [31:0] w);
    m_i = 32'($signed(w) >>> 20);
  endfunction
  function automatic logic [31:0] m_s(input logic [31:0] w);
    m_s = (m_i(w) & ~32'h1F) | ((w >> 7) & 32'h1F);
  endfunction
  function automatic logic [31:0] m_b(input logic [31:0] w);
    m_b = (sgn(w) << 12) | (32'(w[7]) << 11) | (32'(w[30:25]) << 5) | (32'(w[11:8]) << 1);
  endfunction
  function automatic logic [31:0] m_j(input logic [31:0] w);
    m_j = (sgn(w) << 20) | (32'(w[19:12]) << 12) | (32'(w[20]) << 11) | (32'(w[30:21]) << 1);
  endfunction

  function automatic string imm_tag(input logic [6:0] op);
    case (op)
      7'h03, 7'h13, 7'h67: imm_tag = "R1";
      7'h23:               imm_tag = "R2";
      7'h63:               imm_tag = "R3";
      7'h37, 7'h17:        imm_tag = "R4";
      7'h6F:               imm_tag = "R5";
      default:             imm_tag = "R6";
    endcase
  endfunction

  function automatic logic [31:0] m_imm(input logic [31:0] w);
    case (w[6:0])
      7'h03, 7'h13, 7'h67: m_imm = m_i(w);
      7'h23:               m_imm = m_s(w);
      7'h63:               m_imm = m_b(w);
      7'h37, 7'h17:        m_imm = w & 32'hFFFFF000;
      7'h6F:               m_imm = m_j(w);
      default:             m_imm = 32'd0;
    endcase
  endfunction

  function automatic logic m_taken(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, ua, ub;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ua = longint'({32'd0, a}); ub = longint'({32'd0, b});
    if (w[6:0] != 7'h63) return 1'b0;
    case (w[14:12])
      3'd0: return ua == ub;
      3'd1: return ua != ub;
      3'd4: return sa < sb;
      3'd5: return sa >= sb;
      3'd6: return ua < ub;
      3'd7: return ua >= ub;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h instr=%08h pc=%08h sel=%0d",
               tag, act, exp, instr, pc, pc_src);
    end
  endtask

  task automatic compare_all();
    logic [31:0] e_next, e_link;
    logic        e_tk;
    string       nt;
    e_link = pc + 32'd4;
    e_tk   = m_taken(instr, rs1, rs2);
    case (pc_src)
      2'd1: begin e_next = e_tk ? pc + m_b(instr) : e_link; nt = "R9"; end
      2'd2: begin e_next = (rs1 + m_i(instr)) & ~32'd1; nt = "R10"; end
      2'd3: begin e_next = pc + m_j(instr); nt = "R11"; end
      default: begin e_next = e_link; nt = "R8"; end
    endcase
    chk(imm_tag(instr[6:0]), imm, m_imm(instr));
    chk("R7", {31'd0, br_taken}, {31'd0, e_tk});
    chk(nt, next_pc, e_next);
    chk("R12", link, e_link);
  endtask

  task automatic apply(input logic [31:0] w, input logic [31:0] p, input logic [31:0] a,
                       input logic [31:0] b, input logic [1:0] s);
    @(posedge clk);
    #1;
    instr = w; pc = p; rs1 = a; rs2 = b; pc_src = s;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [6:0] ops [9];
    ops = '{7'h03, 7'h13, 7'h67, 7'h23, 7'h63, 7'h37, 7'h17, 7'h6F, 7'h33};
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset state: all-zero inputs, R6 zero imm, R8 sequential address.
    @(negedge clk);
    chk("R6", imm, 32'd0);
    chk("R8", next_pc, 32'd4);
    chk("R7", {31'd0, br_taken}, 32'd0);

    // R7 signed vs unsigned split on the sign bit.
    apply({7'd0, 5'd2, 5'd1, 3'd4, 5'd8, 7'h63}, 32'h100, 32'h8000_0000, 32'd1, 2'd1);
    chk("R7", {31'd0, br_taken}, 32'd1);
    apply({7'd0, 5'd2, 5'd1, 3'd6, 5'd8, 7'h63}, 32'h100, 32'h8000_0000, 32'd1, 2'd1);
    chk("R9", next_pc, 32'h104);
    apply({7'd0, 5'd2, 5'd1, 3'd7, 5'd8, 7'h63}, 32'h100, 32'h8000_0000, 32'd1, 2'd1);
    chk("R9", next_pc, 32'h108);
    // R7 equal operands and reserved compare code.
    apply({7'h40, 5'd2, 5'd1, 3'd0, 5'd0, 7'h63}, 32'h2000, 32'd7, 32'd7, 2'd1);
    chk("R9", next_pc, 32'h2000 - 32'd4096);
    apply({7'd0, 5'd2, 5'd1, 3'd2, 5'd8, 7'h63}, 32'h200, 32'd1, 32'd1, 2'd1);
    chk("R7", {31'd0, br_taken}, 32'd0);
    // R7 taken flag ignores a non-branch opcode with a matching func field.
    apply({7'd0, 5'd2, 5'd1, 3'd0, 5'd8, 7'h33}, 32'h200, 32'd5, 32'd5, 2'd1);
    chk("R7", {31'd0, br_taken}, 32'd0);
    // R10 odd sum has bit 0 cleared.
    apply({12'h003, 5'd1, 3'd0, 5'd1, 7'h67}, 32'h40, 32'h1000, 32'd0, 2'd2);
    chk("R10", next_pc, 32'h1002);
    // R5 most negative jump offset.
    apply(32'h8000_0000 | 32'h6F, 32'h0040_0000, 32'd0, 32'd0, 2'd3);
    chk("R5", imm, 32'hFFF0_0000);
    chk("R11", next_pc, 32'h0030_0000);

    for (int k = 0; k < N_RANDOM; k++) begin
      logic [31:0] w, a, b;
      w = {$urandom()} & 32'hFFFF_FF80;
      w = w | 32'(ops[$urandom_range(0, 8)]);
      a = $urandom();
      b = ($urandom_range(0, 3) == 0) ? a : $urandom();
      if ($urandom_range(0, 3) == 0) b = a ^ 32'h8000_0000;
      apply(w, {$urandom()} & ~32'd3, a, b, 2'($urandom_range(0, 3)));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule